// File: doc/BRIEF.md
# Quadword Byte Rotate and Shift Unit

This block rearranges a 128-bit operand in one of a few fixed ways and returns the result one clock later. It can rotate the whole quadword by a byte count taken either from a second operand or from an immediate. It can shift the quadword by whole bytes, filling with zeros. It can shift each 32-bit word left by a bit count. It can also build a control pattern for inserting a word, where the placement depends on an address formed by adding the low lanes of the two operands.

A caller presents an operation code, the two operands and a 7-bit immediate together with a one-cycle start strobe. On the next rising clock edge the unit captures the result into its output register and raises a valid flag for exactly that one cycle. Between operations the output register keeps its last value. Byte i of any quadword means bits [8i+7:8i], and word w means bits [32w+31:32w].

Top module: `qperm_unit`

## Requirements
- R1: While reset is asserted, and until the first operation completes, `valid` is 0 and `result` is all zeros.
- R2: A cycle with `start` high loads `result` at the next rising edge, and `valid` is high for exactly the cycle after each start cycle. It is low otherwise.
- R3: When `start` is low, `result` keeps its value.
- R4: Operation code 0 is a rotate by a register count. The count s is `opb[3:0]`, and result byte i = `opa` byte ((i + s) mod 16). All other bits of `opb` are ignored.
- R5: Operation code 1 is a rotate by an immediate count. It uses s = `imm[3:0]` with the same byte mapping as R4, and `imm[6:4]` is ignored.
- R6: Operation code 2 is a byte shift with zero fill. The count s is `imm[4:0]`. Result byte i = `opa` byte (i + s) when i + s < 16, and 0 otherwise, so counts 16 to 31 give all zeros. `imm[6:5]` is ignored.
- R7: Operation code 3 shifts each word of `opa` left by s = `imm[6:0]` taken modulo 64 (that is, `imm[5:0]`). A count of 32 or more clears the word, and `imm[6]` is ignored.
- R8: Operation code 4 builds an insertion pattern. Byte i = 0x1F − i, except that word t = bits [3:2] of (`opa[31:0]` + `opb[31:0]`) is replaced by 0x00010203. The upper lanes of both operands are ignored.
- R9: Operation codes 5, 6 and 7 produce an all-zero result and still assert `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation this cycle |
| op | input | 3 | Operation code (see R4 to R9) |
| opa | input | 128 | Source quadword |
| opb | input | 128 | Second operand (register rotate count, address addend) |
| imm | input | 7 | Immediate count |
| result | output | 128 | Registered result |
| valid | output | 1 | High for one cycle when `result` is fresh |

## Verification
The hardest situations to reach from the ports are the ones where only a few operand bits decide the outcome. In the insertion pattern, the slot can be chosen by a carry that rises out of the low bits of the address sum. The rotate count comes from a single nibble of `opb`, while the other 124 bits of `opb` must have no effect. The stimulus picks address pairs whose low bits only reach a given slot through a carry, and it fills every ignored operand and immediate bit with random data while walking all 16 rotate counts, all 32 byte-shift counts and all 64 word-shift counts. Back-to-back starts, followed by idle cycles, exercise the one-cycle valid pulse and the hold behaviour.

// File: rtl/qperm_pkg.sv
package qperm_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ROT_REG  = 3'd0,
    OP_ROT_IMM  = 3'd1,
    OP_BYTE_SHL = 3'd2,
    OP_WORD_SHL = 3'd3,
    OP_INS_MASK = 3'd4
  } qperm_op_e;
endpackage

// File: rtl/qperm_byte_mover.sv
// Moves bytes toward lower indices by a byte count; wraps or zero-fills.
module qperm_byte_mover #(
  parameter int NBYTES    = 16,
  parameter bit ZERO_FILL = 1'b0,
  localparam int DW = NBYTES * 8,
  localparam int CW = $clog2(NBYTES) + 1
) (
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] dout
);
  logic [2*DW-1:0] wide;

  generate
    if (ZERO_FILL) begin : g_fill
      assign wide = {{DW{1'b0}}, din};
    end else begin : g_wrap
      assign wide = {din, din};
    end
  endgenerate

  assign dout = DW'(wide >> {cnt, 3'b000});
endmodule

// File: rtl/qperm_word_shl.sv
// Per-word logical left shift; counts at or beyond the word width clear it.
module qperm_word_shl #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32,
  localparam int SW = $clog2(WORD_W) + 1
) (
  input  logic [NWORDS*WORD_W-1:0] din,
  input  logic [SW-1:0]            cnt,
  output logic [NWORDS*WORD_W-1:0] dout
);
  logic too_far;
  assign too_far = (cnt >= SW'(WORD_W));

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign dout[w*WORD_W +: WORD_W] =
        too_far ? '0 : (din[w*WORD_W +: WORD_W] << cnt);
    end
  endgenerate
endmodule

// File: rtl/qperm_ins_gen.sv
// Builds the word-insertion control pattern for a given slot.
module qperm_ins_gen #(
  parameter int NBYTES = 16,
  parameter int WORD_W = 32,
  localparam int BPW = WORD_W / 8,
  localparam int NW  = NBYTES / BPW,
  localparam int TW  = $clog2(NW)
) (
  input  logic [TW-1:0]         slot,
  output logic [NBYTES*8-1:0]   dout
);
  generate
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam int WI = i / BPW;
      localparam int KI = i % BPW;
      assign dout[i*8 +: 8] = (slot == TW'(WI)) ? 8'(BPW - 1 - KI)
                                                : 8'(2*NBYTES - 1 - i);
    end
  endgenerate
endmodule

// File: rtl/qperm_unit.sv
module qperm_unit
  import qperm_pkg::*;
#(
  parameter int QW_BYTES = 16,
  parameter int WORD_W   = 32,
  parameter int IMM_W    = 7,
  localparam int QW_W    = QW_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OP_W-1:0]     op,
  input  logic [QW_W-1:0]     opa,
  input  logic [QW_W-1:0]     opb,
  input  logic [IMM_W-1:0]    imm,
  output logic [QW_W-1:0]     result,
  output logic                valid
);
  localparam int NWORDS = QW_W / WORD_W;
  localparam int ROT_W  = $clog2(QW_BYTES);
  localparam int BSH_W  = ROT_W + 1;
  localparam int WSH_W  = $clog2(WORD_W) + 1;
  localparam int LOW_W  = $clog2(WORD_W / 8);
  localparam int SLOT_W = $clog2(NWORDS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // operand decode
  qperm_op_e        op_e;
  logic [ROT_W-1:0] rot_cnt;
  logic [BSH_W-1:0] bsh_cnt;
  logic [WSH_W-1:0] wsh_cnt;
  logic [WORD_W-1:0] addr_sum;
  logic [SLOT_W-1:0] ins_slot;

  assign op_e     = qperm_op_e'(op);
  assign rot_cnt  = (op_e == OP_ROT_REG) ? ROT_W'(opb) : ROT_W'(imm);
  assign bsh_cnt  = BSH_W'(imm);
  assign wsh_cnt  = WSH_W'(imm);
  assign addr_sum = WORD_W'(opa) + WORD_W'(opb);
  assign ins_slot = SLOT_W'(addr_sum >> LOW_W);

  logic [QW_W-1:0] rot_res, bsh_res, wsh_res, ins_res;

  qperm_byte_mover #(.NBYTES(QW_BYTES), .ZERO_FILL(1'b0)) u_rot (
    .din (opa),
    .cnt ({1'b0, rot_cnt}),
    .dout(rot_res)
  );

  qperm_byte_mover #(.NBYTES(QW_BYTES), .ZERO_FILL(1'b1)) u_bsh (
    .din (opa),
    .cnt (bsh_cnt),
    .dout(bsh_res)
  );

  qperm_word_shl #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_wsh (
    .din (opa),
    .cnt (wsh_cnt),
    .dout(wsh_res)
  );

  qperm_ins_gen #(.NBYTES(QW_BYTES), .WORD_W(WORD_W)) u_ins (
    .slot(ins_slot),
    .dout(ins_res)
  );

  // next-state
  logic [QW_W-1:0] result_d;
  always_comb begin
    unique case (op_e)
      OP_ROT_REG,
      OP_ROT_IMM:  result_d = rot_res;
      OP_BYTE_SHL: result_d = bsh_res;
      OP_WORD_SHL: result_d = wsh_res;
      OP_INS_MASK: result_d = ins_res;
      default:     result_d = '0;
    endcase
  end

  // registers
  logic [QW_W-1:0] result_q;
  logic            valid_q;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) result_q <= result_d;
    end
  end

  assign result = result_q;
  assign valid  = valid_q;
endmodule

// File: rtl/qperm_chk.sv
module qperm_chk
  import qperm_pkg::*;
#(
  parameter int QW_W   = 128,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OP_W-1:0]  op,
  input logic [QW_W-1:0]  opa,
  input logic [IMM_W-1:0] imm,
  input logic [QW_W-1:0]  result,
  input logic             valid
);
  localparam int BSH_MSB = $clog2(QW_W / 8);
  localparam int WSH_MSB = $clog2(WORD_W);

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));

  p_rot_reg_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_ROT_REG) |=> $countones(result) == $past($countones(opa)));

  p_rot_imm_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_ROT_IMM) |=> $countones(result) == $past($countones(opa)));

  p_bshift_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_BYTE_SHL && imm[BSH_MSB]) |=> result == '0);

  p_wshift_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_WORD_SHL && imm[WSH_MSB]) |=> result == '0);

  p_bad_op_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > OP_INS_MASK) |=> (result == '0 && valid));
endmodule

bind qperm_unit qperm_chk #(.QW_W(QW_W), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_q_n),
  .start (start),
  .op    (op),
  .opa   (opa),
  .imm   (imm),
  .result(result),
  .valid (valid)
);

// File: tb/sim_qperm_unit.sv
module sim_qperm_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [2:0]   op;
  logic [127:0] opa, opb;
  logic [6:0]   imm;
  logic [127:0] result;
  logic         valid;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp;

  always #2 clk = ~clk;

  qperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opa(opa), .opb(opb), .imm(imm), .result(result), .valid(valid)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] model(input logic [2:0] o, input logic [127:0] a,
                                         input logic [127:0] b, input logic [6:0] im);
    logic [127:0] r = '0;
    int s;
    logic [31:0] sum;
    int t;
    case (o)
      3'd0, 3'd1: begin
        s = (o == 3'd0) ? int'(b[3:0]) : int'(im[3:0]);
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = a[((i + s) % 16)*8 +: 8];
      end
      3'd2: begin
        s = int'(im[4:0]);
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = (i + s < 16) ? a[(i + s)*8 +: 8] : 8'h00;
      end
      3'd3: begin
        s = int'(im[5:0]);
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = (s >= 32) ? 32'h0 : (a[w*32 +: 32] << s);
      end
      3'd4: begin
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(8'h1F - i);
        sum = a[31:0] + b[31:0];
        t = int'(sum[3:2]);
        r[t*32 +: 32] = 32'h00010203;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [127:0] a, input logic [127:0] b,
                       input logic [6:0] im, input string tag);
    @(negedge clk);
    op = o; opa = a; opb = b; imm = im; start = 1'b1;
    @(posedge clk);
    last_exp = model(o, a, b, im);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
    opa = rnd128(); opb = rnd128(); imm = 7'($urandom); op = 3'($urandom);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=valid expected=no valid");
        end else begin
          check(tag_q.pop_front(), result, exp_q.pop_front());
        end
      end else if (exp_q.size() != 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=valid low expected=valid high");
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    rst_n = 1'b0; start = 1'b0; op = '0; opa = '0; opb = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R1", {127'b0, valid}, 128'h0);
    check("R1", result, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {127'b0, valid}, 128'h0);

    // R4: all rotate counts, random upper bits of opb
    a = 128'h0F0E0D0C0B0A09080706050403020100;
    for (int s = 0; s < 16; s++) begin
      b = rnd128(); b[3:0] = 4'(s);
      issue(3'd0, (s < 8) ? a : rnd128(), b, 7'($urandom), "R4");
    end
    idle();
    // R3: hold after idle
    @(negedge clk);
    check("R2", {127'b0, valid}, 128'h0);
    check("R3", result, last_exp);

    // R5: immediate rotate, junk in imm[6:4]
    for (int s = 0; s < 16; s++)
      issue(3'd1, rnd128(), rnd128(), {3'($urandom), 4'(s)}, "R5");
    idle();

    // R6: every byte shift count, junk in imm[6:5]
    for (int s = 0; s < 32; s++)
      issue(3'd2, rnd128(), rnd128(), {2'($urandom), 5'(s)}, "R6");
    idle();

    // R7: every word shift count with imm[6] both ways
    for (int s = 0; s < 64; s++)
      issue(3'd3, rnd128(), rnd128(), {1'($urandom), 6'(s)}, "R7");
    idle();

    // R8: slot reached through carries, noise in upper lanes
    for (int t = 0; t < 4; t++) begin
      a = rnd128(); b = rnd128();
      a[31:0] = 32'h0000_0003 + 32'(t*4 - 4);
      b[31:0] = 32'h0000_0001;
      issue(3'd4, a, b, 7'($urandom), "R8");
      a[31:0] = 32'hFFFF_FFFF;
      b[31:0] = 32'(t*4 + 1);
      issue(3'd4, a, b, 7'($urandom), "R8");
    end
    idle();

    // R9: unused codes
    for (int o = 5; o < 8; o++)
      issue(3'(o), rnd128(), rnd128(), 7'($urandom), "R9");
    idle();
    @(negedge clk);
    check("R3", result, 128'h0);

    // mixed random traffic with gaps
    for (int n = 0; n < 200; n++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      issue(o, rnd128(), rnd128(), 7'($urandom),
            (o == 3'd0) ? "R4" : (o == 3'd1) ? "R5" : (o == 3'd2) ? "R6" :
            (o == 3'd3) ? "R7" : (o == 3'd4) ? "R8" : "R9");
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R3", result, last_exp);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule